// File: doc/BRIEF.md
# Multi-Thread Time-Gated Egress Scheduler

This block drives the transmission gates of a switch egress path from one shared table of timeslots. Each timeslot names a set of output ports, a traffic-class mask whose cleared bits mark the classes allowed to send, and a duration counted in delta units. Up to eight execution threads walk the table at the same time. Each thread owns one contiguous range of slots, from its entry address up to its end index. When it passes the end index it returns to its entry address, so every thread repeats its own cycle forever.

A thread starts once the free-running time counter reaches the common schedule start time plus that thread's own entry offset. A slot stays in force for as many delta-tick strobes as its duration field says, and then the thread moves to the next slot. Each thread drives its own per-port, per-class gate vector and an active flag. Threads outside the active count, threads that have not started yet and threads that have stopped all hold their gates fully open. Table contents are loaded through a single write port, usually while the schedule is stopped.

Top module: `gs_sched_top`

## Requirements
- R1: After reset, every thread is inactive, no error flag is set and every bit of `gate_open` is 1.
- R2: With `sched_run` high and thread i enabled, thread i stays inactive while `now_time` < `base_time` + its entry offset. At the first rising edge where `now_time` >= that sum, it becomes active and loads the slot at its entry address.
- R3: An active thread keeps its current slot for exactly as many `delta_tick` strobes as the slot's duration field, then moves to the next address. Clock edges without a strobe change nothing.
- R4: A thread that leaves the slot at its end index continues at its entry address.
- R5: Bit `(t*NP + p)*NC + c` of `gate_open` is thread t, port p, class c. For a port set in the slot's port mask, class c is open (1) exactly when bit c of the class mask is 0. Ports outside the mask are all open.
- R6: `act_cnt` holds the number of used threads minus one. Threads with an index above `act_cnt` never become active, and their gates stay all 1.
- R7: An enabled thread whose entry offset is 0 raises its `ep_err` bit on the next edge and does not start, whatever the time.
- R8: When `sched_run` is low at a rising edge, after that edge every thread is inactive, every error flag is clear and every gate is open.
- R9: Two enabled threads with separate slot ranges and separate offsets start and advance independently on the same strobes.
- R10: A slot written through the write port (`tbl_we` high at a rising edge) is used by a thread that loads that address afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_run | input | 1 | Schedule enable; low stops all threads |
| now_time | input | TIME_W | Free-running time in delta units |
| base_time | input | TIME_W | Common schedule start time |
| act_cnt | input | TW | Number of used threads minus one |
| ep_delta | input | NT*TIME_W | Per-thread start offset past `base_time` |
| ep_addr | input | NT*AW | Per-thread entry slot address |
| end_idx | input | NT*AW | Per-thread last slot address |
| delta_tick | input | 1 | One-cycle strobe per elapsed delta unit |
| tbl_we | input | 1 | Slot table write enable |
| tbl_addr | input | AW | Slot table write address |
| tbl_delta | input | DLY_W | Slot duration in delta units |
| tbl_ports | input | NP | Slot destination-port mask |
| tbl_classes | input | NC | Slot class mask; cleared bits are open gates |
| gate_open | output | NT*NP*NC | Registered gate state per thread, port and class |
| thread_active | output | NT | Thread is running its cycle |
| ep_err | output | NT | Enabled thread has a zero start offset |

## Verification
The assertions assume that the entry offsets, entry addresses, end indices, active count and start time only change while `sched_run` is low. They also assume that every range satisfies entry address <= end index within the table, and that no slot used by a running thread has a zero duration. The bench reprograms the configuration and the table only after a stop. Every slot it writes has a duration of at least 1, and the unused threads get the end index of the last used thread. The only illegal value the bench drives on purpose is a zero start offset, to exercise the error path.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_RUN   = 2'd1,
    TS_FAULT = 2'd2
  } gs_state_e;
endpackage

// File: rtl/gs_slot_table.sv
module gs_slot_table #(
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int SLOT_W = 20,
  parameter int NRD    = 8
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [SLOT_W-1:0]     wdata,
  input  logic [NRD*AW-1:0]     raddr,
  output logic [NRD*SLOT_W-1:0] rdata
);
  logic [SLOT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r*SLOT_W +: SLOT_W] = mem[raddr[r*AW +: AW]];
  end
endmodule

// File: rtl/gs_gate_decode.sv
module gs_gate_decode #(
  parameter int NP = 4,
  parameter int NC = 8
) (
  input  logic [NP-1:0]    port_mask,
  input  logic [NC-1:0]    class_mask,
  output logic [NP*NC-1:0] gates
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    assign gates[p*NC +: NC] = port_mask[p] ? ~class_mask : {NC{1'b1}};
  end
endmodule

// File: rtl/gs_thread.sv
module gs_thread
  import gs_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DLY_W = 8,
  parameter int NP    = 4,
  parameter int NC    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      due,
  input  logic                      ep_zero,
  input  logic [AW-1:0]             entry_addr,
  input  logic [AW-1:0]             last_addr,
  input  logic                      tick,
  output logic [AW-1:0]             rd_addr,
  input  logic [DLY_W+NP+NC-1:0]    rd_slot,
  output logic                      active,
  output logic                      err,
  output logic [NP*NC-1:0]          gates
);
  gs_state_e          st_q;
  logic [AW-1:0]      cur_q;
  logic [DLY_W-1:0]   remain_q;
  logic [NP*NC-1:0]   gates_q;
  logic [NP*NC-1:0]   slot_gates;
  logic [DLY_W-1:0]   slot_delta;

  assign slot_delta = rd_slot[NP+NC +: DLY_W];

  gs_gate_decode #(.NP(NP), .NC(NC)) u_dec (
    .port_mask (rd_slot[NC +: NP]),
    .class_mask(rd_slot[0 +: NC]),
    .gates     (slot_gates)
  );

  always_comb begin
    if (st_q != TS_RUN) rd_addr = entry_addr;
    else if (cur_q == last_addr) rd_addr = entry_addr;
    else rd_addr = cur_q + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q     <= TS_IDLE;
      cur_q    <= '0;
      remain_q <= '0;
      gates_q  <= '1;
    end else begin
      unique case (st_q)
        TS_IDLE: begin
          if (ep_zero) begin
            st_q <= TS_FAULT;
          end else if (due) begin
            st_q     <= TS_RUN;
            cur_q    <= rd_addr;
            remain_q <= slot_delta;
            gates_q  <= slot_gates;
          end
        end
        TS_RUN: begin
          if (tick) begin
            if (remain_q <= DLY_W'(1)) begin
              cur_q    <= rd_addr;
              remain_q <= slot_delta;
              gates_q  <= slot_gates;
            end else begin
              remain_q <= remain_q - DLY_W'(1);
            end
          end
        end
        default: st_q <= TS_FAULT;
      endcase
    end
  end

  assign active = (st_q == TS_RUN);
  assign err    = (st_q == TS_FAULT);
  assign gates  = gates_q;
endmodule

// File: rtl/gs_sched_top.sv
module gs_sched_top #(
  parameter int NT     = 8,
  parameter int NP     = 4,
  parameter int NC     = 8,
  parameter int DEPTH  = 16,
  parameter int TIME_W = 16,
  parameter int DLY_W  = 8,
  parameter int TW     = $clog2(NT),
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sched_run,
  input  logic [TIME_W-1:0]     now_time,
  input  logic [TIME_W-1:0]     base_time,
  input  logic [TW-1:0]         act_cnt,
  input  logic [NT*TIME_W-1:0]  ep_delta,
  input  logic [NT*AW-1:0]      ep_addr,
  input  logic [NT*AW-1:0]      end_idx,
  input  logic                  delta_tick,
  input  logic                  tbl_we,
  input  logic [AW-1:0]         tbl_addr,
  input  logic [DLY_W-1:0]      tbl_delta,
  input  logic [NP-1:0]         tbl_ports,
  input  logic [NC-1:0]         tbl_classes,
  output logic [NT*NP*NC-1:0]   gate_open,
  output logic [NT-1:0]         thread_active,
  output logic [NT-1:0]         ep_err
);
  localparam int SLOT_W = DLY_W + NP + NC;
  localparam int GW     = NP * NC;

  logic [NT*AW-1:0]     rd_addr;
  logic [NT*SLOT_W-1:0] rd_slot;

  gs_slot_table #(.DEPTH(DEPTH), .AW(AW), .SLOT_W(SLOT_W), .NRD(NT)) u_tbl (
    .clk  (clk),
    .we   (tbl_we),
    .waddr(tbl_addr),
    .wdata({tbl_delta, tbl_ports, tbl_classes}),
    .raddr(rd_addr),
    .rdata(rd_slot)
  );

  for (genvar t = 0; t < NT; t++) begin : g_thr
    localparam logic [TW-1:0] IDX = TW'(t);
    logic              en;
    logic              due;
    logic [TIME_W:0]   start_at;

    assign start_at = {1'b0, base_time} + {1'b0, ep_delta[t*TIME_W +: TIME_W]};
    assign due      = ({1'b0, now_time} >= start_at);
    assign en       = sched_run && (IDX <= act_cnt);

    gs_thread #(.AW(AW), .DLY_W(DLY_W), .NP(NP), .NC(NC)) u_thr (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .due       (due),
      .ep_zero   (ep_delta[t*TIME_W +: TIME_W] == '0),
      .entry_addr(ep_addr[t*AW +: AW]),
      .last_addr (end_idx[t*AW +: AW]),
      .tick      (delta_tick),
      .rd_addr   (rd_addr[t*AW +: AW]),
      .rd_slot   (rd_slot[t*SLOT_W +: SLOT_W]),
      .active    (thread_active[t]),
      .err       (ep_err[t]),
      .gates     (gate_open[t*GW +: GW])
    );
  end
endmodule

// File: rtl/gs_sched_sva.sv
module gs_sched_sva #(
  parameter int NT     = 8,
  parameter int NP     = 4,
  parameter int NC     = 8,
  parameter int DEPTH  = 16,
  parameter int TIME_W = 16,
  parameter int DLY_W  = 8,
  parameter int TW     = $clog2(NT),
  parameter int AW     = $clog2(DEPTH)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sched_run,
  input logic [TIME_W-1:0]     now_time,
  input logic [TIME_W-1:0]     base_time,
  input logic [TW-1:0]         act_cnt,
  input logic [NT*TIME_W-1:0]  ep_delta,
  input logic [NT*AW-1:0]      ep_addr,
  input logic [NT*AW-1:0]      end_idx,
  input logic                  delta_tick,
  input logic                  tbl_we,
  input logic [AW-1:0]         tbl_addr,
  input logic [DLY_W-1:0]      tbl_delta,
  input logic [NP-1:0]         tbl_ports,
  input logic [NC-1:0]         tbl_classes,
  input logic [NT*NP*NC-1:0]   gate_open,
  input logic [NT-1:0]         thread_active,
  input logic [NT-1:0]         ep_err
);
  localparam int GW = NP * NC;

  // R8: a stop releases everything on the next edge
  p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
    !sched_run |=> (thread_active == '0 && ep_err == '0 && (&gate_open)));

  for (genvar t = 0; t < NT; t++) begin : g_chk
    localparam logic [TW-1:0] IDX = TW'(t);

    // R6: threads above the active count stay off with open gates
    p_beyond_count_r6: assert property (@(posedge clk) disable iff (rst)
      (act_cnt < IDX) |=> (!thread_active[t] && (&gate_open[t*GW +: GW])));

    // R2: no start before the thread's own start time
    p_no_early_r2: assert property (@(posedge clk) disable iff (rst)
      (!thread_active[t] &&
       ({1'b0, now_time} < ({1'b0, base_time} + {1'b0, ep_delta[t*TIME_W +: TIME_W]})))
      |=> !thread_active[t]);

    // R7: a zero start offset flags an error and blocks the start
    p_zero_offset_r7: assert property (@(posedge clk) disable iff (rst)
      (sched_run && (IDX <= act_cnt) && !thread_active[t] &&
       ep_delta[t*TIME_W +: TIME_W] == '0) |=> (ep_err[t] && !thread_active[t]));

    // R7: a faulted thread never drives gates
    p_fault_open_r7: assert property (@(posedge clk) disable iff (rst)
      ep_err[t] |-> (!thread_active[t] && (&gate_open[t*GW +: GW])));
  end
endmodule

bind gs_sched_top gs_sched_sva #(
  .NT(NT), .NP(NP), .NC(NC), .DEPTH(DEPTH), .TIME_W(TIME_W), .DLY_W(DLY_W)
) u_sva (.*);

// File: tb/gs_sched_top_test.sv
module gs_sched_top_test;
  localparam int NT = 8, NP = 4, NC = 8, DEPTH = 16, TIME_W = 16, DLY_W = 8;
  localparam int TW = $clog2(NT), AW = $clog2(DEPTH), GW = NP * NC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sched_run = 1'b0;
  logic [TIME_W-1:0] now_time = '0;
  logic [TIME_W-1:0] base_time = '0;
  logic [TW-1:0]     act_cnt = '0;
  logic [TIME_W-1:0] b_ep  [NT];
  logic [AW-1:0]     b_adr [NT];
  logic [AW-1:0]     b_end [NT];
  logic [NT*TIME_W-1:0] ep_delta;
  logic [NT*AW-1:0]  ep_addr, end_idx;
  logic delta_tick = 1'b0;
  logic tbl_we = 1'b0;
  logic [AW-1:0] tbl_addr = '0;
  logic [DLY_W-1:0] tbl_delta = '0;
  logic [NP-1:0] tbl_ports = '0;
  logic [NC-1:0] tbl_classes = '0;
  logic [NT*GW-1:0] gate_open;
  logic [NT-1:0] thread_active, ep_err;

  logic [NP-1:0] m_p [DEPTH];
  logic [NC-1:0] m_c [DEPTH];

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      ep_delta[t*TIME_W +: TIME_W] = b_ep[t];
      ep_addr[t*AW +: AW]          = b_adr[t];
      end_idx[t*AW +: AW]          = b_end[t];
    end
  end

  gs_sched_top #(.NT(NT), .NP(NP), .NC(NC), .DEPTH(DEPTH),
                 .TIME_W(TIME_W), .DLY_W(DLY_W)) uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [GW-1:0] exp_gates(logic [NP-1:0] pm, logic [NC-1:0] cm);
    logic [GW-1:0] g;
    for (int p = 0; p < NP; p++) g[p*NC +: NC] = pm[p] ? ~cm : {NC{1'b1}};
    return g;
  endfunction

  function automatic logic [GW-1:0] thr_gates(int t);
    return gate_open[t*GW +: GW];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    delta_tick = 1'b1;
    step();
    delta_tick = 1'b0;
  endtask

  task automatic wr_slot(int a, int d, logic [NP-1:0] pm, logic [NC-1:0] cm);
    tbl_we = 1'b1; tbl_addr = AW'(a); tbl_delta = DLY_W'(d);
    tbl_ports = pm; tbl_classes = cm;
    m_p[a] = pm; m_c[a] = cm;
    step();
    tbl_we = 1'b0;
  endtask

  task automatic chk_slot(string req, int t, int a);
    check(req, 64'(thr_gates(t)), 64'(exp_gates(m_p[a], m_c[a])));
  endtask

  task automatic t_reset();
    check("R1 active", 64'(thread_active), 64'(0));
    check("R1 err", 64'(ep_err), 64'(0));
    check("R1 gates", 64'(&gate_open), 64'(1));
  endtask

  task automatic t_load();
    wr_slot(0, 2, 4'b0001, 8'h0F);
    wr_slot(1, 3, 4'b0010, 8'hF0);
    wr_slot(2, 1, 4'b0001, 8'hFF);
    wr_slot(3, 2, 4'b1000, 8'h01);
    wr_slot(4, 1, 4'b0100, 8'h80);
    base_time = 16'd10;
    act_cnt = TW'(1);
    for (int t = 0; t < NT; t++) begin
      b_ep[t] = 16'd1; b_adr[t] = '0; b_end[t] = AW'(4);
    end
    b_ep[0] = 16'd3; b_adr[0] = AW'(0); b_end[0] = AW'(2);
    b_ep[1] = 16'd5; b_adr[1] = AW'(3); b_end[1] = AW'(4);
  endtask

  task automatic t_start();
    now_time = 16'd12; sched_run = 1'b1;
    step();
    check("R2 early", 64'(thread_active[0]), 64'(0));
    now_time = 16'd13;
    step();
    check("R2 start t0", 64'(thread_active[0]), 64'(1));
    chk_slot("R5 first slot t0", 0, 0);
    check("R9 t1 waits", 64'(thread_active[1]), 64'(0));
    now_time = 16'd15;
    step();
    check("R9 start t1", 64'(thread_active[1]), 64'(1));
    chk_slot("R9 first slot t1", 1, 3);
    check("R6 upper idle", 64'(thread_active[NT-1:2]), 64'(0));
    check("R6 upper open", 64'(&gate_open[NT*GW-1:2*GW]), 64'(1));
  endtask

  task automatic t_walk();
    step(); step();
    chk_slot("R3 no tick hold", 0, 0);
    tick(); chk_slot("R3 t0 tick1", 0, 0); chk_slot("R3 t1 tick1", 1, 3);
    tick(); chk_slot("R3 t0 tick2", 0, 1); chk_slot("R3 t1 tick2", 1, 4);
    tick(); chk_slot("R3 t0 tick3", 0, 1); chk_slot("R4 t1 wrap", 1, 3);
    tick(); chk_slot("R3 t0 tick4", 0, 1); chk_slot("R9 t1 tick4", 1, 3);
    tick(); chk_slot("R3 t0 tick5", 0, 2); chk_slot("R9 t1 tick5", 1, 4);
    tick(); chk_slot("R4 t0 wrap", 0, 0); chk_slot("R4 t1 wrap2", 1, 3);
  endtask

  task automatic t_stop();
    sched_run = 1'b0;
    step();
    check("R8 inactive", 64'(thread_active), 64'(0));
    check("R8 gates open", 64'(&gate_open), 64'(1));
    check("R8 err clear", 64'(ep_err), 64'(0));
  endtask

  task automatic t_zero();
    b_ep[0] = 16'd0;
    sched_run = 1'b1;
    step();
    check("R7 err set", 64'(ep_err[0]), 64'(1));
    check("R7 no start", 64'(thread_active[0]), 64'(0));
    check("R7 t1 unaffected", 64'(thread_active[1]), 64'(1));
    step();
    check("R7 stays off", 64'(thread_active[0]), 64'(0));
    check("R7 gates open", 64'(&thr_gates(0)), 64'(1));
    t_stop();
    b_ep[0] = 16'd3;
  endtask

  task automatic t_count();
    act_cnt = TW'(0);
    sched_run = 1'b1;
    step();
    check("R6 t0 runs", 64'(thread_active[0]), 64'(1));
    check("R6 t1 held", 64'(thread_active[1]), 64'(0));
    check("R6 t1 open", 64'(&thr_gates(1)), 64'(1));
    t_stop();
    act_cnt = TW'(1);
  endtask

  task automatic t_rewrite();
    wr_slot(0, 2, 4'b1111, 8'hAA);
    sched_run = 1'b1;
    step();
    chk_slot("R10 new slot", 0, 0);
    check("R10 value", 64'(thr_gates(0)), 64'(32'h55555555));
    t_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_load();
    t_start();
    t_walk();
    t_stop();
    t_zero();
    t_count();
    t_rewrite();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule